// File: doc/BRIEF.md
# ALU with Two-Level Operation Decode

This block is the arithmetic and logic unit of a simple processor datapath, together with the small decoder that sits in front of it. The main controller does not pick the exact ALU operation. It sends only a 2-bit operation class. For register-register instructions, the 6-bit function field of the instruction then selects the operation. The decoder merges the two into a 3-bit internal operation code.

The unit is purely combinational. A single code selects one of five functions on two 32-bit operands: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. The internal code values are AND 000, OR 001, add 010, subtract 110 and set-on-less-than 111. Bit 2 of the code marks the operations that run through the subtractor, so that bit alone inverts the second operand and supplies the carry-in.

A zero flag accompanies the result. A branch-equal instruction can judge equality from that flag after a subtraction.

Top module: `alu_top`

## Requirements
- R1: Operation class 00 (load/store) makes the result the sum of the operands modulo 2^32, whatever the function field.
- R2: Operation class 01 (branch-equal) makes the result A minus B modulo 2^32, whatever the function field. With equal operands the result is 0 and the zero flag is 1.
- R3: Under operation class 10, function field 100000 gives A plus B and function field 100010 gives A minus B, both modulo 2^32.
- R4: Under operation class 10, function field 100100 gives the bitwise AND of the operands and function field 100101 gives the bitwise OR.
- R5: Under operation class 10, function field 101010 compares the operands as signed two's-complement values. The result is 1 when A is less than B and 0 otherwise, with bits 31..1 always 0. This holds even when the subtraction overflows, for example with the most negative value.
- R6: Every other function field under class 10 gives A plus B. Class 11 also gives A plus B for every function field. No input combination leaves the operation undefined.
- R7: The zero flag is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field, instruction bits 5..0 |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | ALU result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The bench sweeps all four operation classes against all 64 function-field values. Each combination is applied to every pair drawn from a set of corner operands: zero, one, all ones, the most negative value, the most positive value and an alternating bit pattern.

This full sweep tells the five recognised function fields apart from the default-to-add fields. It also shows that class 00 and class 01 ignore the function field. The corner pairs separate a signed compare from an unsigned one and catch the overflow case in set-on-less-than. Equal operands drive the zero flag high under subtraction.

A pseudo-random operand phase then exercises carries and borrows across all bit positions.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FUNCT_W = 6;

    typedef enum logic [1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_ARITH  = 2'b10,
        CLS_SPARE  = 2'b11
    } op_class_e;

    // bit 2 set marks codes that use the subtractor path
    typedef enum logic [2:0] {
        CODE_AND = 3'b000,
        CODE_OR  = 3'b001,
        CODE_ADD = 3'b010,
        CODE_SUB = 3'b110,
        CODE_SLT = 3'b111
    } alu_code_e;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    typedef struct packed {
        alu_code_e code;
        logic      invert_b;
    } alu_ctl_t;

    function automatic alu_code_e funct_to_code(input logic [FUNCT_W-1:0] fn);
        alu_code_e c;
        case (fn)
            FN_ADD:  c = CODE_ADD;
            FN_SUB:  c = CODE_SUB;
            FN_AND:  c = CODE_AND;
            FN_OR:   c = CODE_OR;
            FN_SLT:  c = CODE_SLT;
            default: c = CODE_ADD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
    import alu_pkg::*;
(
    input  logic [1:0]         op_class,
    input  logic [FUNCT_W-1:0] funct,
    output alu_ctl_t           ctl
);

    alu_code_e code_q;

    always_comb begin
        case (op_class_e'(op_class))
            CLS_MEM:    code_q = CODE_ADD;
            CLS_BRANCH: code_q = CODE_SUB;
            CLS_ARITH:  code_q = funct_to_code(funct);
            default:    code_q = CODE_ADD;
        endcase
        ctl.code     = code_q;
        ctl.invert_b = code_q[2];
    end

    always_comb begin
        if (!$isunknown(op_class)) begin
            a_r1_mem_adds: assert (op_class != 2'b00 || ctl.code == CODE_ADD)
                else $error("R1: memory class did not select add");
            a_r2_branch_subs: assert (op_class != 2'b01 || ctl.code == CODE_SUB)
                else $error("R2: branch class did not select subtract");
            a_r6_spare_adds: assert (op_class != 2'b11 || ctl.code == CODE_ADD)
                else $error("R6: spare class did not select add");
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_ctl_t         ctl,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             ovf;
    logic             less;

    // shared adder: invert_b both complements B and feeds the carry-in
    always_comb begin
        b_eff = ctl.invert_b ? ~b : b;
        sum   = a + b_eff + {{(WIDTH-1){1'b0}}, ctl.invert_b};
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        less  = sum[MSB] ^ ovf;
    end

    always_comb begin
        case (ctl.code)
            CODE_AND: y = a & b;
            CODE_OR:  y = a | b;
            CODE_SLT: y = {{(WIDTH-1){1'b0}}, less};
            default:  y = sum;
        endcase
    end

    always_comb begin
        if (!$isunknown({ctl, a, b})) begin
            a_r5_slt_upper_clear: assert (ctl.code != CODE_SLT || y[MSB:1] == '0)
                else $error("R5: compare result has upper bits set");
            a_r5_slt_signed: assert (ctl.code != CODE_SLT || y[0] == ($signed(a) < $signed(b)))
                else $error("R5: compare disagrees with signed order");
            a_r2_equal_sub_zero: assert (ctl.code != CODE_SUB || a != b || y == '0)
                else $error("R2: subtract of equal operands not zero");
        end
    end

endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
    parameter int WIDTH = 32,
    parameter int CHUNK = 8
) (
    input  logic [WIDTH-1:0] val,
    output logic             is_zero
);

    localparam int NCH = (WIDTH + CHUNK - 1) / CHUNK;
    localparam int PADW = NCH * CHUNK;

    logic [PADW-1:0] padded;
    logic [NCH-1:0]  chunk_any;

    assign padded = {{(PADW-WIDTH){1'b0}}, val};

    for (genvar i = 0; i < NCH; i++) begin : g_chunk
        assign chunk_any[i] = |padded[i*CHUNK +: CHUNK];
    end

    assign is_zero = ~|chunk_any;

endmodule

// File: rtl/alu_top.sv
module alu_top
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]         op_class,
    input  logic [FUNCT_W-1:0] funct,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    output logic [WIDTH-1:0]   result,
    output logic               zero
);

    alu_ctl_t ctl;

    alu_ctl_decode u_dec (
        .op_class (op_class),
        .funct    (funct),
        .ctl      (ctl)
    );

    alu_core #(.WIDTH(WIDTH)) u_core (
        .ctl (ctl),
        .a   (opnd_a),
        .b   (opnd_b),
        .y   (result)
    );

    zero_detect #(.WIDTH(WIDTH), .CHUNK(8)) u_zero (
        .val     (result),
        .is_zero (zero)
    );

    always_comb begin
        if (!$isunknown({op_class, funct, opnd_a, opnd_b})) begin
            a_r7_zero_matches: assert (zero == (result == '0))
                else $error("R7: zero flag disagrees with result");
            a_r6_no_unknown: assert (!$isunknown(result))
                else $error("R6: result has unknown bits");
        end
    end

endmodule

// File: tb/sim_alu_top.sv
`timescale 1ns/1ps
module sim_alu_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_class = 2'b00;
    logic [5:0]  funct = 6'd0;
    logic [31:0] opnd_a = 32'd0;
    logic [31:0] opnd_b = 32'd0;
    logic [31:0] result;
    logic        zero;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    alu_top u0 (
        .op_class (op_class),
        .funct    (funct),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .zero     (zero)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] expect_res(input logic [1:0] c, input logic [5:0] f,
                                              input logic [31:0] a, input logic [31:0] b);
        if (c == 2'b01) return a - b;
        if (c == 2'b10) begin
            if (f == 6'b100010) return a - b;
            if (f == 6'b100100) return a & b;
            if (f == 6'b100101) return a | b;
            if (f == 6'b101010) return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        end
        return a + b;
    endfunction

    function automatic string req_of(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return "R1";
        if (c == 2'b01) return "R2";
        if (c == 2'b11) return "R6";
        case (f)
            6'b100000, 6'b100010: return "R3";
            6'b100100, 6'b100101: return "R4";
            6'b101010:            return "R5";
            default:              return "R6";
        endcase
    endfunction

    task automatic apply(input logic [1:0] c, input logic [5:0] f,
                         input logic [31:0] a, input logic [31:0] b);
        logic [31:0] exp_r;
        @(negedge clk);
        op_class = c; funct = f; opnd_a = a; opnd_b = b;
        #1;
        exp_r = expect_res(c, f, a, b);
        checks++;
        if (result !== exp_r) begin
            errors++;
            $display("FAIL %s: cls=%b fn=%b a=%h b=%h actual=%h expected=%h",
                     req_of(c, f), c, f, a, b, result, exp_r);
        end
        checks++;
        if (zero !== (exp_r == 32'd0)) begin  // R7
            errors++;
            $display("FAIL R7: zero flag a=%h b=%h actual=%b expected=%b",
                     a, b, zero, exp_r == 32'd0);
        end
    endtask

    logic [31:0] corners [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                                 32'h7FFF_FFFF, 32'hA5A5_5A5A};

    initial begin
        logic [31:0] lfsr;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset/idle state: all-zero inputs give add of zeros, zero flag high (R1, R7)
        apply(2'b00, 6'd0, 32'd0, 32'd0);
        // R5 overflow corner: most negative vs positive
        apply(2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001);
        apply(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000);
        // R2 equal operands give zero flag
        apply(2'b01, 6'b111111, 32'h1234_5678, 32'h1234_5678);
        // exhaustive class x funct sweep over corner pairs (R1..R7)
        for (int c = 0; c < 4; c++)
            for (int f = 0; f < 64; f++)
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        apply(c[1:0], f[5:0], corners[i], corners[j]);
        // pseudo-random operands on the recognised codes
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ra, rb;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = (n % 7 == 0) ? ra : lfsr;
            case (n % 6)
                0: apply(2'b00, 6'b000000, ra, rb);
                1: apply(2'b01, 6'b000000, ra, rb);
                2: apply(2'b10, 6'b100000, ra, rb);
                3: apply(2'b10, 6'b100010, ra, rb);
                4: apply(2'b10, 6'b100100 | {5'd0, lfsr[0]}, ra, rb);
                default: apply(2'b10, 6'b101010, ra, rb);
            endcase
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule